// File: doc/BRIEF.md
# Peripheral DMA Request Handshake Unit

This unit sits between sixteen numbered peripheral request lines and a set of DMA channels. Each line carries four inputs from its peripheral: a single request (one item ready), a burst request (several items ready), and the last-transfer variants of both. Each channel is programmed with the line number it serves, an enable and a flow mode. A per-channel state machine accepts a request from its line and latches the request type and the last-transfer flag. It presents them to the channel until the channel reports the service done. It then returns a one-cycle clear pulse on that line's clear output.

Two line numbers are not fed by peripherals. They are fed by external pins through a two-flop synchroniser and a rising-edge detector. A detected edge stays pending as a single request until the clear for that line is issued. Two further line numbers are reserved and never request. Data movement and arbitration between channels are handled elsewhere.

The channel state machine has three states: `ST_IDLE`, `ST_SERVE` and `ST_CLEAR`. It has three transitions. ACCEPT takes IDLE to SERVE when the channel is enabled and its line shows a single or burst request. DONE takes SERVE to CLEAR when the channel reports service. RELEASE takes CLEAR back to IDLE unconditionally after one cycle.

Top module: `dmh_req_unit`

## Requirements
- R1: An enabled channel in IDLE whose selected line shows only a single request raises `ch_req` one clock later, with `ch_burst` low.
- R2: A burst request raises `ch_req` with `ch_burst` high one clock later. When single and burst are both active, the burst is taken (`ch_burst` = 1).
- R3: In peripheral-flow mode (`ch_pflow` = 1), `ch_last` equals the last-burst input when the burst is taken, and the last-single input when the single is taken.
- R4: In controller-flow mode (`ch_pflow` = 0), the last inputs are ignored and `ch_last` stays 0.
- R5: When `ch_done` is high while `ch_req` is high, `ch_req` drops one clock later. In that same cycle, bit `sel` of `per_clr` is high for exactly one cycle.
- R6: While a request is being served, changes on the line's inputs do not alter `ch_burst` or `ch_last`. A request still present after the clear is accepted again only after one IDLE cycle.
- R7: A rising edge on `ext_pin[i]` becomes a single request on line 8+i. The channel's `ch_req` rises on the fourth clock edge after the pin rises. `ch_burst` and `ch_last` stay low, and the peripheral inputs of lines 8 and 9 are ignored.
- R8: A detected pin edge stays pending, even after the pin falls, until the clear for its line is issued. A pin held high after the clear raises no new request.
- R9: Lines 10 and 11 are reserved: their inputs are ignored, no request is raised and their `per_clr` bits stay 0.
- R10: `ch_sel` (4 bits per channel, channel c at bits 4c+3:4c) selects the line. A channel with `ch_en` low raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| per_sreq | input | 16 | Single request, one bit per line |
| per_breq | input | 16 | Burst request, one bit per line |
| per_lsreq | input | 16 | Last single request, one bit per line |
| per_lbreq | input | 16 | Last burst request, one bit per line |
| ext_pin | input | 2 | External request pins, edge-detected into lines 8 and 9 |
| ch_sel | input | 32 | Line number per channel, 4 bits each |
| ch_en | input | 8 | Channel enable |
| ch_pflow | input | 8 | 1 = peripheral is flow controller |
| ch_done | input | 8 | Channel reports the current request serviced |
| ch_req | output | 8 | Service request to each channel |
| ch_burst | output | 8 | 1 = burst request, 0 = single |
| ch_last | output | 8 | Last-transfer indication |
| per_clr | output | 16 | One-cycle request-clear pulse per line |

## Verification
The bench drives single and burst requests together in both flow modes. A unit that preferred the single, or that passed last flags through in controller-flow mode, would show the wrong `ch_burst` or `ch_last`. It changes the line inputs during service and holds a request through the clear. A design that re-sampled its inputs would alter the type mid-service, and one that skipped the idle cycle would re-raise `ch_req` too early. The external pins are checked for exact synchroniser latency, for an edge that must stay pending while the channel is disabled, and for a pin held high that must not re-trigger. Requests on reserved lines and on disabled channels are checked for silence.

// File: rtl/dmh_pkg.sv
package dmh_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SERVE = 2'd1,
        ST_CLEAR = 2'd2
    } chan_state_e;
endpackage

// File: rtl/dmh_ext_edge.sv
module dmh_ext_edge #(
    parameter int NUM_EXT = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EXT-1:0] pin,
    input  logic [NUM_EXT-1:0] clr,
    output logic [NUM_EXT-1:0] pend
);
    logic [NUM_EXT-1:0] sync1, sync2, prev;
    logic [NUM_EXT-1:0] rise;

    assign rise = sync2 & ~prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1 <= '0;
            sync2 <= '0;
            prev  <= '0;
            pend  <= '0;
        end else begin
            sync1 <= pin;
            sync2 <= sync1;
            prev  <= sync2;
            // a fresh edge wins over a clear in the same cycle
            pend  <= rise | (pend & ~clr);
        end
    end

    for (genvar i = 0; i < NUM_EXT; i++) begin : g_chk
        assert_pend_from_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pend[i]) |-> $past(rise[i]));
        assert_pend_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (pend[i] && !clr[i]) |=> pend[i]);
    end
endmodule

// File: rtl/dmh_line_map.sv
module dmh_line_map #(
    parameter int                   NUM_LINES = 16,
    parameter int                   NUM_EXT   = 2,
    parameter int                   EXT_BASE  = 8,
    parameter logic [NUM_LINES-1:0] RSVD_MASK = 16'h0C00
) (
    input  logic [NUM_LINES-1:0] per_sreq,
    input  logic [NUM_LINES-1:0] per_breq,
    input  logic [NUM_LINES-1:0] per_lsreq,
    input  logic [NUM_LINES-1:0] per_lbreq,
    input  logic [NUM_EXT-1:0]   ext_pend,
    output logic [NUM_LINES-1:0] eff_s,
    output logic [NUM_LINES-1:0] eff_b,
    output logic [NUM_LINES-1:0] eff_ls,
    output logic [NUM_LINES-1:0] eff_lb
);
    always_comb begin
        eff_s  = per_sreq  & ~RSVD_MASK;
        eff_b  = per_breq  & ~RSVD_MASK;
        eff_ls = per_lsreq & ~RSVD_MASK;
        eff_lb = per_lbreq & ~RSVD_MASK;
        for (int e = 0; e < NUM_EXT; e++) begin
            // pin-fed lines: single requests only, never last
            eff_s[EXT_BASE+e]  = ext_pend[e];
            eff_b[EXT_BASE+e]  = 1'b0;
            eff_ls[EXT_BASE+e] = 1'b0;
            eff_lb[EXT_BASE+e] = 1'b0;
        end
    end
endmodule

// File: rtl/dmh_chan_fsm.sv
module dmh_chan_fsm
    import dmh_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int SEL_W     = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 pflow,
    input  logic [SEL_W-1:0]     sel,
    input  logic [NUM_LINES-1:0] line_s,
    input  logic [NUM_LINES-1:0] line_b,
    input  logic [NUM_LINES-1:0] line_ls,
    input  logic [NUM_LINES-1:0] line_lb,
    input  logic                 done,
    output logic                 req,
    output logic                 burst,
    output logic                 last,
    output logic [NUM_LINES-1:0] clr_vec
);
    chan_state_e      state;
    logic             burst_q, last_q;
    logic [SEL_W-1:0] sel_q;
    logic             s_in, b_in;

    assign s_in = line_s[sel];
    assign b_in = line_b[sel];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            burst_q <= 1'b0;
            last_q  <= 1'b0;
            sel_q   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (en && (s_in || b_in)) begin        // ACCEPT
                    state   <= ST_SERVE;
                    burst_q <= b_in;
                    last_q  <= pflow && (b_in ? line_lb[sel] : line_ls[sel]);
                    sel_q   <= sel;
                end
                ST_SERVE: if (done) state <= ST_CLEAR;          // DONE
                ST_CLEAR: state <= ST_IDLE;                     // RELEASE
                default:  state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        req     = (state == ST_SERVE);
        burst   = req && burst_q;
        last    = req && last_q;
        clr_vec = '0;
        if (state == ST_CLEAR) clr_vec[sel_q] = 1'b1;
    end

    assert_clear_after_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req && done) |=> ($countones(clr_vec) == 1) && !req);
    assert_clear_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_vec != '0) |=> (clr_vec == '0));
    assert_type_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !done) |=> req && $stable(burst) && $stable(last));
    assert_burst_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && en && s_in && b_in) |=> burst);
    assert_last_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && en && !pflow) |=> !last);
    assert_disabled_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !en) |=> !req);
endmodule

// File: rtl/dmh_req_unit.sv
module dmh_req_unit #(
    parameter int                   NUM_LINES = 16,
    parameter int                   NUM_CH    = 8,
    parameter int                   NUM_EXT   = 2,
    parameter int                   EXT_BASE  = 8,
    parameter logic [NUM_LINES-1:0] RSVD_MASK = 16'h0C00
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [NUM_LINES-1:0]                per_sreq,
    input  logic [NUM_LINES-1:0]                per_breq,
    input  logic [NUM_LINES-1:0]                per_lsreq,
    input  logic [NUM_LINES-1:0]                per_lbreq,
    input  logic [NUM_EXT-1:0]                  ext_pin,
    input  logic [NUM_CH*$clog2(NUM_LINES)-1:0] ch_sel,
    input  logic [NUM_CH-1:0]                   ch_en,
    input  logic [NUM_CH-1:0]                   ch_pflow,
    input  logic [NUM_CH-1:0]                   ch_done,
    output logic [NUM_CH-1:0]                   ch_req,
    output logic [NUM_CH-1:0]                   ch_burst,
    output logic [NUM_CH-1:0]                   ch_last,
    output logic [NUM_LINES-1:0]                per_clr
);
    localparam int SEL_W = $clog2(NUM_LINES);

    logic [NUM_EXT-1:0]   ext_pend, ext_clr;
    logic [NUM_LINES-1:0] eff_s, eff_b, eff_ls, eff_lb;
    logic [NUM_LINES-1:0] ch_clr [NUM_CH];

    assign ext_clr = per_clr[EXT_BASE +: NUM_EXT];

    dmh_ext_edge #(.NUM_EXT(NUM_EXT)) u_ext (
        .clk(clk), .rst_n(rst_n), .pin(ext_pin), .clr(ext_clr), .pend(ext_pend)
    );

    dmh_line_map #(
        .NUM_LINES(NUM_LINES), .NUM_EXT(NUM_EXT),
        .EXT_BASE(EXT_BASE), .RSVD_MASK(RSVD_MASK)
    ) u_map (
        .per_sreq(per_sreq), .per_breq(per_breq),
        .per_lsreq(per_lsreq), .per_lbreq(per_lbreq),
        .ext_pend(ext_pend),
        .eff_s(eff_s), .eff_b(eff_b), .eff_ls(eff_ls), .eff_lb(eff_lb)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        dmh_chan_fsm #(.NUM_LINES(NUM_LINES), .SEL_W(SEL_W)) u_fsm (
            .clk(clk), .rst_n(rst_n),
            .en(ch_en[c]), .pflow(ch_pflow[c]),
            .sel(ch_sel[c*SEL_W +: SEL_W]),
            .line_s(eff_s), .line_b(eff_b), .line_ls(eff_ls), .line_lb(eff_lb),
            .done(ch_done[c]),
            .req(ch_req[c]), .burst(ch_burst[c]), .last(ch_last[c]),
            .clr_vec(ch_clr[c])
        );
    end

    always_comb begin
        per_clr = '0;
        for (int c = 0; c < NUM_CH; c++) per_clr = per_clr | ch_clr[c];
    end

    assert_rsvd_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (per_clr & RSVD_MASK) == '0);
endmodule

// File: tb/test_dmh_req_unit.sv
`timescale 1ns/1ps
module test_dmh_req_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] per_sreq = '0, per_breq = '0, per_lsreq = '0, per_lbreq = '0;
    logic [1:0]  ext_pin = '0;
    logic [31:0] ch_sel = '0;
    logic [7:0]  ch_en = '0, ch_pflow = '0, ch_done = '0;
    logic [7:0]  ch_req, ch_burst, ch_last;
    logic [15:0] per_clr;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #4 clk = ~clk;   // 125 MHz

    dmh_req_unit i_dmh_req_unit (
        .clk(clk), .rst_n(rst_n),
        .per_sreq(per_sreq), .per_breq(per_breq),
        .per_lsreq(per_lsreq), .per_lbreq(per_lbreq),
        .ext_pin(ext_pin), .ch_sel(ch_sel), .ch_en(ch_en),
        .ch_pflow(ch_pflow), .ch_done(ch_done),
        .ch_req(ch_req), .ch_burst(ch_burst), .ch_last(ch_last),
        .per_clr(per_clr)
    );

    typedef struct packed {
        logic [3:0] sel;
        logic s, b, ls, lb, pf;
        logic er, eb, el;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t TBL [NV] = '{
        '{4'd3,  1'b1,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0},
        '{4'd3,  1'b0,1'b1,1'b0,1'b0,1'b0, 1'b1,1'b1,1'b0},
        '{4'd5,  1'b1,1'b1,1'b0,1'b0,1'b0, 1'b1,1'b1,1'b0},
        '{4'd0,  1'b1,1'b0,1'b1,1'b0,1'b1, 1'b1,1'b0,1'b1},
        '{4'd7,  1'b0,1'b1,1'b0,1'b1,1'b1, 1'b1,1'b1,1'b1},
        '{4'd12, 1'b1,1'b0,1'b1,1'b0,1'b0, 1'b1,1'b0,1'b0},
        '{4'd15, 1'b0,1'b1,1'b0,1'b1,1'b0, 1'b1,1'b1,1'b0},
        '{4'd1,  1'b1,1'b1,1'b1,1'b0,1'b1, 1'b1,1'b1,1'b0},
        '{4'd13, 1'b1,1'b1,1'b0,1'b1,1'b1, 1'b1,1'b1,1'b1},
        '{4'd4,  1'b1,1'b0,1'b0,1'b1,1'b1, 1'b1,1'b0,1'b0},
        '{4'd10, 1'b1,1'b1,1'b1,1'b1,1'b1, 1'b0,1'b0,1'b0},
        '{4'd8,  1'b1,1'b1,1'b1,1'b1,1'b1, 1'b0,1'b0,1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic set_sel(input int ch, input int line);
        ch_sel[ch*4 +: 4] = line[3:0];
    endtask

    task automatic clear_lines();
        per_sreq = '0; per_breq = '0; per_lsreq = '0; per_lbreq = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R5 reset per_clr", 32'(per_clr), 0);
        chk("R1 reset ch_req", 32'(ch_req), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset ch_req", 32'(ch_req), 0);

        // table walk on channel 0: R1 R2 R3 R4 R5 R9
        ch_en = 8'h01;
        for (int i = 0; i < NV; i++) begin
            set_sel(0, int'(TBL[i].sel));
            ch_pflow[0] = TBL[i].pf;
            per_sreq[TBL[i].sel]  = TBL[i].s;
            per_breq[TBL[i].sel]  = TBL[i].b;
            per_lsreq[TBL[i].sel] = TBL[i].ls;
            per_lbreq[TBL[i].sel] = TBL[i].lb;
            @(negedge clk);
            chk($sformatf("R1 R9 vec%0d req", i), 32'(ch_req[0]), 32'(TBL[i].er));
            if (TBL[i].er) begin
                chk($sformatf("R2 vec%0d burst", i), 32'(ch_burst[0]), 32'(TBL[i].eb));
                chk($sformatf("R3 R4 vec%0d last", i), 32'(ch_last[0]), 32'(TBL[i].el));
                ch_done[0] = 1'b1;
                @(negedge clk);
                chk($sformatf("R5 vec%0d clr", i), 32'(per_clr), 32'(1) << TBL[i].sel);
                chk($sformatf("R5 vec%0d req drop", i), 32'(ch_req[0]), 0);
                ch_done[0] = 1'b0;
                clear_lines();
                @(negedge clk);
                chk($sformatf("R5 vec%0d clr pulse end", i), 32'(per_clr), 0);
            end else begin
                chk($sformatf("R9 vec%0d clr", i), 32'(per_clr), 0);
                clear_lines();
                @(negedge clk);
            end
        end

        // R6: inputs change during service, request held through clear
        set_sel(0, 6); ch_pflow[0] = 1'b1;
        per_sreq[6] = 1'b1;
        @(negedge clk);
        chk("R6 accept single", 32'({ch_req[0], ch_burst[0], ch_last[0]}), 32'b100);
        per_breq[6] = 1'b1; per_lbreq[6] = 1'b1; per_lsreq[6] = 1'b1;
        @(negedge clk);
        chk("R6 held type 1", 32'({ch_req[0], ch_burst[0], ch_last[0]}), 32'b100);
        @(negedge clk);
        chk("R6 held type 2", 32'({ch_req[0], ch_burst[0], ch_last[0]}), 32'b100);
        ch_done[0] = 1'b1;
        @(negedge clk);
        chk("R5 R6 clear line 6", 32'(per_clr), 32'h0040);
        ch_done[0] = 1'b0;
        @(negedge clk);
        chk("R6 idle gap", 32'(ch_req[0]), 0);
        @(negedge clk);
        chk("R6 re-accept burst last", 32'({ch_req[0], ch_burst[0], ch_last[0]}), 32'b111);
        ch_done[0] = 1'b1; clear_lines();
        @(negedge clk);
        ch_done[0] = 1'b0; ch_en[0] = 1'b0;
        @(negedge clk);

        // R10: two channels on line 6, one disabled; channel 0 elsewhere
        set_sel(0, 2); set_sel(1, 6); set_sel(2, 6);
        ch_en = 8'h03;
        per_sreq[6] = 1'b1;
        @(negedge clk);
        chk("R10 routed channel", 32'(ch_req), 32'h02);
        ch_done[1] = 1'b1; per_sreq[6] = 1'b0;
        @(negedge clk);
        chk("R10 clear routed", 32'(per_clr), 32'h0040);
        ch_done[1] = 1'b0; ch_en = 8'h00;
        @(negedge clk);

        // R7: pin 0 edge to channel 3, peripheral inputs of line 8 ignored
        set_sel(3, 8); ch_pflow[3] = 1'b1; ch_en[3] = 1'b1;
        per_breq[8] = 1'b1; per_lbreq[8] = 1'b1; per_lsreq[8] = 1'b1;
        ext_pin[0] = 1'b1;
        repeat (3) @(negedge clk);
        chk("R7 not before 4th edge", 32'(ch_req[3]), 0);
        @(negedge clk);
        chk("R7 pin request", 32'({ch_req[3], ch_burst[3], ch_last[3]}), 32'b100);
        ch_done[3] = 1'b1;
        @(negedge clk);
        chk("R7 clear line 8", 32'(per_clr), 32'h0100);
        ch_done[3] = 1'b0;
        repeat (10) @(negedge clk);
        chk("R8 held pin no retrigger", 32'(ch_req[3]), 0);
        clear_lines(); ext_pin[0] = 1'b0; ch_en[3] = 1'b0;

        // R8: pin 1 pulse while channel 4 disabled stays pending
        set_sel(4, 9);
        ext_pin[1] = 1'b1;
        repeat (3) @(negedge clk);
        ext_pin[1] = 1'b0;
        repeat (10) @(negedge clk);
        chk("R8 disabled no req", 32'(ch_req[4]), 0);
        ch_en[4] = 1'b1;
        @(negedge clk);
        chk("R8 pending served", 32'(ch_req[4]), 1);
        ch_done[4] = 1'b1;
        @(negedge clk);
        chk("R8 clear line 9", 32'(per_clr), 32'h0200);
        ch_done[4] = 1'b0;
        repeat (3) @(negedge clk);
        chk("R8 pending consumed", 32'(ch_req[4]), 0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule